// File: doc/BRIEF.md
# Sector ECC Correction Applier

This block sits behind a BCH-style decoder that has already located the bad bytes of one 512-byte sector. It takes the decoder's two packed 32-bit error-status words and its 32-bit error-pattern word, and repairs the sector buffer held in a local byte-wide RAM. A start strobe latches all of these inputs. The block then walks through the reported errors in index order. For each error that is in range, it reads the buffer byte, XORs in the matching pattern byte and writes the result back.

Two modes are supported. In main-data mode, every offset inside the sector is repaired. In spare-area mode, only the leading meaningful bytes are repaired. A layout select sets that length to 44 bytes or 84 bytes. The rest of the spare sector is filler, and any error found there makes the whole sector uncorrectable. When the walk ends, the block raises a one-cycle done pulse and presents a three-way verdict.

All pins are plain control, status or memory pins, with no valid/ready flow. Back-pressure works as follows: the block accepts a start only while `busy_o` is low. A start strobe raised while the block is busy is dropped without effect, so the caller must wait for `done_o` before issuing the next job.

Top module: `sector_ecc_fixer`

## Requirements
- R1: The error count is bits 28:26 of `stat0_i`. The verdict encoding on `status_o` is 0 = clean, 1 = corrected, 2 = uncorrectable. A count of 0 gives verdict 0 and no RAM access.
- R2: A count of 5, 6 or 7 gives verdict 2 and no RAM access.
- R3: The four 10-bit error offsets are slot0 = `stat0_i[9:0]`, slot1 = `stat0_i[25:16]`, slot2 = `stat1_i[9:0]` and slot3 = `stat1_i[25:16]`. Only the first N slots are processed, where N is the count, and they are processed in slot order.
- R4: Slot i is repaired by XORing `pattern_i[8i+7:8i]` into the buffer byte at its offset. This is a read-modify-write, and other bytes are left unchanged.
- R5: A slot offset of 512 or more is skipped with no RAM access. It does not alter the verdict.
- R6: In spare mode (`spare_mode_i`=1), only offsets below the effective length are repaired. The effective length is 44 when `wide_page_i`=0 and 84 when `wide_page_i`=1. Both selects are sampled at start.
- R7: In spare mode, an offset in the range from the effective length up to 511 leaves its byte untouched and forces verdict 2. The other valid slots are still repaired.
- R8: In main mode, every offset from 0 to 511 is repaired, and a count of 1 to 4 with no filler hit gives verdict 1.
- R9: Each repair asserts `mem_rd_o` for one cycle, with read data valid on the next cycle. That next cycle asserts `mem_wr_o` to the same address.
- R10: `done_o` is a one-cycle pulse. `status_o` changes only in the done cycle and then holds until the next done.
- R11: A start strobe that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Job start strobe, accepted when idle |
| spare_mode_i | input | 1 | 1 = spare-area mode, 0 = main data |
| wide_page_i | input | 1 | Spare layout: 0 = 44-byte, 1 = 84-byte effective length |
| stat0_i | input | 32 | Status word 0: count and offsets of slots 0 and 1 |
| stat1_i | input | 32 | Status word 1: offsets of slots 2 and 3 |
| pattern_i | input | 32 | Four XOR pattern bytes, byte i for slot i |
| mem_addr_o | output | 9 | Buffer RAM byte address |
| mem_rd_o | output | 1 | Buffer RAM read strobe |
| mem_rdata_i | input | 8 | Buffer RAM read data, one cycle after the read |
| mem_wr_o | output | 1 | Buffer RAM write strobe |
| mem_wdata_o | output | 8 | Buffer RAM write data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle job completion pulse |
| status_o | output | 2 | Verdict: 0 clean, 1 corrected, 2 uncorrectable |

## Verification
The assertions check the behaviour that holds on every cycle. Each write follows a read of the same address, and no read happens for a count of 0 or above 4. No spare-mode read falls at or past the effective length. The done pulse lasts one cycle, the verdict moves only on done, and a running job is not disturbed until its done. Only the bench scenarios show the effects that depend on data. These are the actual byte values after the XOR, the choice of which slots count, the skipping of out-of-range offsets, the forced failure on a filler hit, and the dropping of a second job's data when it arrives mid-run.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  typedef enum logic [1:0] {
    VERD_CLEAN = 2'd0,
    VERD_FIXED = 2'd1,
    VERD_FAIL  = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    SLOT_APPLY = 2'd0,
    SLOT_SKIP  = 2'd1,
    SLOT_FILL  = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/ecc_slot_unpack.sv
module ecc_slot_unpack #(
  parameter int SLOTS = 4,
  parameter int OFF_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [31:0]                   stat0,
  input  logic [31:0]                   stat1,
  input  logic [31:0]                   pat,
  output logic [SLOTS-1:0][OFF_W-1:0]   offs,
  output logic [SLOTS-1:0][BYTE_W-1:0]  pats
);
  // even slots take the low half of a word, odd slots the high half
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int HALF_LSB = (s % 2) * 16;
    if (s / 2 == 0) begin : g_w0
      assign offs[s] = stat0[HALF_LSB +: OFF_W];
    end else begin : g_w1
      assign offs[s] = stat1[HALF_LSB +: OFF_W];
    end
    assign pats[s] = pat[s*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ecc_slot_judge.sv
module ecc_slot_judge import ecc_fix_pkg::*; #(
  parameter int OFF_W = 10,
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_LEN_NARROW = 44,
  parameter int SPARE_LEN_WIDE = 84
) (
  input  logic [OFF_W-1:0] off,
  input  logic             spare,
  input  logic             wide,
  output slot_kind_e       kind
);
  localparam logic [OFF_W-1:0] LIM_SECT = OFF_W'(SECTOR_BYTES);
  localparam logic [OFF_W-1:0] LIM_NAR  = OFF_W'(SPARE_LEN_NARROW);
  localparam logic [OFF_W-1:0] LIM_WID  = OFF_W'(SPARE_LEN_WIDE);

  logic [OFF_W-1:0] eff_len;
  assign eff_len = wide ? LIM_WID : LIM_NAR;

  always_comb begin
    if (off >= LIM_SECT)              kind = SLOT_SKIP;
    else if (spare && off >= eff_len) kind = SLOT_FILL;
    else                              kind = SLOT_APPLY;
  end
endmodule

// File: rtl/ecc_rmw_engine.sv
module ecc_rmw_engine import ecc_fix_pkg::*; #(
  parameter int CNT_W = 3,
  parameter int MAX_FIX = 4,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  cnt,
  input  slot_kind_e        kind,
  input  logic [BYTE_W-1:0] slot_pat,
  input  logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  idx,
  output logic              rd,
  output logic              wr,
  output logic [BYTE_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        verdict
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_PICK, S_READ, S_WRITE, S_DONE} st_e;
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FIX);

  st_e  st_q;
  logic fill_hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      idx        <= '0;
      fill_hit_q <= 1'b0;
      verdict    <= VERD_CLEAN;
    end else begin
      unique case (st_q)
        S_IDLE: if (go) st_q <= S_EVAL;
        S_EVAL: begin
          idx        <= '0;
          fill_hit_q <= 1'b0;
          if (cnt == '0) begin
            verdict <= VERD_CLEAN;
            st_q    <= S_DONE;
          end else if (cnt > MAX_C) begin
            verdict <= VERD_FAIL;
            st_q    <= S_DONE;
          end else begin
            st_q <= S_PICK;
          end
        end
        S_PICK: begin
          if (idx == cnt) begin
            verdict <= fill_hit_q ? VERD_FAIL : VERD_FIXED;
            st_q    <= S_DONE;
          end else if (kind == SLOT_APPLY) begin
            st_q <= S_READ;
          end else begin
            if (kind == SLOT_FILL) fill_hit_q <= 1'b1;
            idx <= idx + 1'b1;
          end
        end
        S_READ:  st_q <= S_WRITE;
        S_WRITE: begin
          idx  <= idx + 1'b1;
          st_q <= S_PICK;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd    = (st_q == S_READ);
  assign wr    = (st_q == S_WRITE);
  assign wdata = rdata ^ slot_pat;
  assign busy  = (st_q != S_IDLE);
  assign done  = (st_q == S_DONE);
endmodule

// File: rtl/sector_ecc_fixer.sv
module sector_ecc_fixer import ecc_fix_pkg::*; #(
  parameter int ADDR_W = 9,
  parameter int OFF_W = 10,
  parameter int SLOTS = 4,
  parameter int CNT_LSB = 26,
  parameter int CNT_W = 3,
  parameter int SPARE_LEN_NARROW = 44,
  parameter int SPARE_LEN_WIDE = 84
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              spare_mode_i,
  input  logic              wide_page_i,
  input  logic [31:0]       stat0_i,
  input  logic [31:0]       stat1_i,
  input  logic [31:0]       pattern_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  localparam int BYTE_W = 8;
  localparam int SECTOR_BYTES = 1 << ADDR_W;
  localparam int SEL_W = $clog2(SLOTS);

  logic [31:0] stat0_q, stat1_q, pat_q;
  logic        spare_q, wide_q;
  logic        go;

  assign go = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat0_q <= '0;
      stat1_q <= '0;
      pat_q   <= '0;
      spare_q <= 1'b0;
      wide_q  <= 1'b0;
    end else if (go) begin
      stat0_q <= stat0_i;
      stat1_q <= stat1_i;
      pat_q   <= pattern_i;
      spare_q <= spare_mode_i;
      wide_q  <= wide_page_i;
    end
  end

  logic [SLOTS-1:0][OFF_W-1:0]  offs;
  logic [SLOTS-1:0][BYTE_W-1:0] pats;

  ecc_slot_unpack #(.SLOTS(SLOTS), .OFF_W(OFF_W), .BYTE_W(BYTE_W)) u_unpack (
    .stat0 (stat0_q),
    .stat1 (stat1_q),
    .pat   (pat_q),
    .offs  (offs),
    .pats  (pats)
  );

  logic [CNT_W-1:0]  idx;
  logic [SEL_W-1:0]  sel;
  logic [OFF_W-1:0]  sel_off;
  logic [BYTE_W-1:0] sel_pat;
  slot_kind_e        kind;

  assign sel     = idx[SEL_W-1:0];
  assign sel_off = offs[sel];
  assign sel_pat = pats[sel];

  ecc_slot_judge #(
    .OFF_W(OFF_W), .SECTOR_BYTES(SECTOR_BYTES),
    .SPARE_LEN_NARROW(SPARE_LEN_NARROW), .SPARE_LEN_WIDE(SPARE_LEN_WIDE)
  ) u_judge (
    .off   (sel_off),
    .spare (spare_q),
    .wide  (wide_q),
    .kind  (kind)
  );

  ecc_rmw_engine #(.CNT_W(CNT_W), .MAX_FIX(SLOTS), .BYTE_W(BYTE_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .cnt      (stat0_q[CNT_LSB +: CNT_W]),
    .kind     (kind),
    .slot_pat (sel_pat),
    .rdata    (mem_rdata_i),
    .idx      (idx),
    .rd       (mem_rd_o),
    .wr       (mem_wr_o),
    .wdata    (mem_wdata_o),
    .busy     (busy_o),
    .done     (done_o),
    .verdict  (status_o)
  );

  assign mem_addr_o = sel_off[ADDR_W-1:0];
endmodule

// File: rtl/sector_ecc_fixer_chk.sv
module sector_ecc_fixer_chk #(
  parameter int ADDR_W = 9,
  parameter int SPARE_LEN_NARROW = 44,
  parameter int SPARE_LEN_WIDE = 84
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              spare_mode_i,
  input logic              wide_page_i,
  input logic [31:0]       stat0_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        status_o
);
  logic [2:0] cnt_c;
  logic       spare_c, wide_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_c   <= '0;
      spare_c <= 1'b0;
      wide_c  <= 1'b0;
    end else if (start_i && !busy_o) begin
      cnt_c   <= stat0_i[28:26];
      spare_c <= spare_mode_i;
      wide_c  <= wide_page_i;
    end
  end

  logic [ADDR_W-1:0] eff_c;
  assign eff_c = wide_c ? ADDR_W'(SPARE_LEN_WIDE) : ADDR_W'(SPARE_LEN_NARROW);

  p_no_access_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (cnt_c >= 3'd1 && cnt_c <= 3'd4));
  p_rd_then_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (mem_wr_o && $stable(mem_addr_o)));
  p_wr_needs_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> $past(mem_rd_o));
  p_spare_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && spare_c) |-> (mem_addr_o < eff_c));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_status_moves_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_o) |-> done_o);
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
  p_no_idle_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> busy_o);
endmodule

bind sector_ecc_fixer sector_ecc_fixer_chk #(
  .ADDR_W(ADDR_W), .SPARE_LEN_NARROW(SPARE_LEN_NARROW), .SPARE_LEN_WIDE(SPARE_LEN_WIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .spare_mode_i(spare_mode_i),
  .wide_page_i(wide_page_i), .stat0_i(stat0_i), .mem_addr_o(mem_addr_o),
  .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .busy_o(busy_o), .done_o(done_o),
  .status_o(status_o)
);

// File: tb/tb_sector_ecc_fixer.sv
module tb_sector_ecc_fixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, spare_mode_i = 1'b0, wide_page_i = 1'b0;
  logic [31:0] stat0_i = '0, stat1_i = '0, pattern_i = '0;
  logic [8:0]  mem_addr_o;
  logic        mem_rd_o, mem_wr_o, busy_o, done_o;
  logic [7:0]  mem_rdata_i = '0, mem_wdata_o;
  logic [1:0]  status_o;

  int total = 0, bad = 0;
  int wr_count = 0;
  logic [7:0] ram [512];
  logic [7:0] exp_ram [512];

  always #5 clk = ~clk;

  sector_ecc_fixer dut (.*);

  always @(posedge clk) begin
    if (mem_wr_o) begin
      ram[mem_addr_o] <= mem_wdata_o;
      wr_count <= wr_count + 1;
    end
    if (mem_rd_o) mem_rdata_i <= ram[mem_addr_o];
  end

  initial begin
    #1ms;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic fill_ram();
    for (int i = 0; i < 512; i++) begin
      ram[i] = 8'(i * 7 + 3);
      exp_ram[i] = 8'(i * 7 + 3);
    end
  endtask

  function automatic logic [31:0] w0(int c, int o0, int o1);
    return {3'b0, 3'(c), 10'(o1), 6'b0, 10'(o0)};
  endfunction
  function automatic logic [31:0] w1(int o2, int o3);
    return {6'b0, 10'(o3), 6'b0, 10'(o2)};
  endfunction

  // run one job; intr=1 pulses a second start with other data while busy (R11)
  task automatic run_job(string req, int c, int o0, int o1, int o2, int o3,
                         logic [31:0] pat, bit spare, bit wide, bit intr);
    int offs[4] = '{o0, o1, o2, o3};
    int eff = wide ? 84 : 44;
    int exp_wr = 0, exp_st, w_before, mism = 0, waited = 0;
    bit fill = 0, seen = 0;
    if (c == 0) exp_st = 0;
    else if (c > 4) exp_st = 2;
    else begin
      for (int i = 0; i < c; i++) begin
        if (offs[i] >= 512) continue;
        if (spare && offs[i] >= eff) fill = 1;
        else begin
          exp_ram[offs[i]] = exp_ram[offs[i]] ^ pat[8*i +: 8];
          exp_wr++;
        end
      end
      exp_st = fill ? 2 : 1;
    end
    @(negedge clk);
    w_before = wr_count;
    stat0_i = w0(c, o0, o1); stat1_i = w1(o2, o3); pattern_i = pat;
    spare_mode_i = spare; wide_page_i = wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (intr) begin
      @(negedge clk);
      stat0_i = w0(4, 1, 2); stat1_i = w1(3, 4); pattern_i = 32'hFFFF_FFFF;
      spare_mode_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!seen && waited < 100) begin
      if (done_o) seen = 1;
      else begin @(negedge clk); waited++; end
    end
    check({req, " done seen"}, int'(seen), 1);
    check({req, " status"}, int'(status_o), exp_st);
    @(negedge clk);
    check("R10 done single cycle", int'(done_o), 0);
    check({req, " status held"}, int'(status_o), exp_st);
    repeat (4) @(negedge clk);
    check({req, " idle after job"}, int'(busy_o), 0);
    check({req, " ram writes"}, wr_count - w_before, exp_wr);
    for (int i = 0; i < 512; i++) if (ram[i] !== exp_ram[i]) mism++;
    check({req, " ram contents"}, mism, 0);
  endtask

  task automatic t_reset();
    check("R10 reset done", int'(done_o), 0);
    check("R10 reset busy", int'(busy_o), 0);
    check("R1 reset status", int'(status_o), 0);
    check("R9 reset no write", int'(mem_wr_o), 0);
  endtask

  task automatic t_clean();      run_job("R1 count zero",        0, 5, 6, 7, 8, 32'h11223344, 0, 0, 0); endtask
  task automatic t_uncorr();
    run_job("R2 count five",  5, 5, 6, 7, 8, 32'h11223344, 0, 0, 0);
    run_job("R2 count seven", 7, 9, 9, 9, 9, 32'hAABBCCDD, 0, 0, 0);
  endtask
  task automatic t_main_four();  run_job("R4 R8 four slots",     4, 0, 511, 300, 100, 32'hA1B2C3D4, 0, 0, 0); endtask
  task automatic t_partial();    run_job("R3 first two only",    2, 10, 20, 30, 40, 32'h0F0E0D0C, 0, 0, 0); endtask
  task automatic t_skip();       run_job("R5 offset over sector",3, 512, 1023, 77, 0, 32'h55AA33CC, 0, 0, 0); endtask
  task automatic t_same();       run_job("R9 same byte twice",   2, 50, 50, 0, 0, 32'h0000F00F, 0, 0, 0); endtask
  task automatic t_spare();
    run_job("R6 spare narrow",  2, 0, 43, 0, 0, 32'h00008181, 1, 0, 0);
    run_job("R6 spare wide",    3, 44, 83, 60, 0, 32'h00242424, 1, 1, 0);
  endtask
  task automatic t_fill();
    run_job("R7 spare filler narrow", 3, 5, 44, 300, 0, 32'h00777777, 1, 0, 0);
    run_job("R7 spare filler wide",   2, 84, 10, 0, 0, 32'h00006666, 1, 1, 0);
    run_job("R7 filler past sector skip", 1, 600, 0, 0, 0, 32'h000000FF, 1, 0, 0);
  endtask
  task automatic t_busy();       run_job("R11 start while busy", 1, 200, 0, 0, 0, 32'h0000005A, 0, 0, 1); endtask

  initial begin
    fill_ram();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_uncorr();
    t_main_four();
    t_partial();
    t_skip();
    t_same();
    t_spare();
    t_fill();
    t_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule